// File: doc/BRIEF.md
# Ping-Pong Sample Capture Controller

This block collects a stream of input samples into memory without processor involvement, using two equal banks that alternate roles. One bank belongs to the capture side and receives samples in address order. The other bank belongs to the processor, which reads it through a dedicated read port. Samples arrive on a valid/ready interface and are stored at the current fill position.

When the capture bank holds exactly `BLK_LEN` samples, the two banks swap roles on the same clock edge that stores the last sample. The next sample therefore lands at address 0 of the other bank, with no idle cycle. Each completed block raises a level interrupt, which the processor clears with an acknowledge. If a block completes while the previous interrupt is still pending, a sticky overrun flag records the lost deadline. The swap happens anyway.

Top module: `pingpong_capture`

## Requirements
- R1: While `rst_n` is low, `s_ready` is 0. After reset, bank 0 belongs to the capture side (`cpu_bank` = 1), `fill_level` = 0, `irq` = 0 and `overrun` = 0. `s_ready` is 1 from the first clock edge after reset is released.
- R2: Each sample accepted (`s_valid` and `s_ready` both high at a rising edge) is written into the capture-side bank at address `fill_level`, and `fill_level` then increases by one. `fill_level` never reaches `BLK_LEN`.
- R3: On the edge that accepts the `BLK_LEN`-th sample of a block, `fill_level` returns to 0 and `cpu_bank` toggles. No other edge changes `cpu_bank`.
- R4: `cpu_rdata` combinationally shows the word at `cpu_addr` of the bank named by `cpu_bank`. A completed block is therefore readable at addresses 0 to `BLK_LEN`-1, in arrival order.
- R5: `irq` is set on the edge that completes a block and stays set until acknowledged.
- R6: `irq_ack` high at an edge clears `irq`, unless a block completes on that same edge. In that case `irq` stays set and `overrun` is not set.
- R7: A block completing while `irq` is set and `irq_ack` is low sets `overrun`, and the swap still occurs. `overrun` then stays set until reset.
- R8: A `cpu_addr` at or above `BLK_LEN` reads as 0.
- R9: A cycle with `s_valid` low leaves `fill_level` and both banks unchanged.
- R10: Capture writes never change the processor-owned bank. While a new block fills, the processor still reads the completed one unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample present |
| s_data | input | DATA_W | Input sample value |
| s_ready | output | 1 | Controller can take a sample |
| cpu_addr | input | ADDR_W | Processor read address within its bank |
| cpu_rdata | output | DATA_W | Word read from the processor-owned bank |
| cpu_bank | output | 1 | Index of the bank the processor owns |
| fill_level | output | ADDR_W | Samples already stored in the capture bank |
| irq | output | 1 | Block-complete interrupt, level |
| irq_ack | input | 1 | Processor acknowledge for `irq` |
| overrun | output | 1 | Sticky: a block completed before the previous interrupt was acknowledged |

## Verification
The bound assertions check the following on every cycle:
- the fill bound;
- the wrap of the fill count and the bank toggle at the last sample;
- bank stability on all other edges;
- interrupt set, hold and clear, including the priority of completion over acknowledge;
- overrun setting and stickiness;
- the fact that idle cycles leave the fill count alone.

Only the bench scenarios show what the banks contain: that samples land in arrival order, skip the idle cycles, and are handed over intact. They also show that the processor bank stays frozen during the next fill, and that out-of-range addresses read 0.

// File: rtl/pp_pkg.sv
package pp_pkg;
   localparam int unsigned NUM_BANKS = 2;

   // width of a pointer that indexes n entries, never below one bit
   function automatic int unsigned ptr_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 6,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic              rd_in_range;

   assign rd_in_range = ({1'b0, rd_addr} < (ADDR_W+1)'(DEPTH));

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_comb begin
      rd_data = '0;
      if (rd_in_range) rd_data = mem[rd_addr];
   end
endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl #(
   parameter int unsigned BLK_LEN = 6,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   output logic [ADDR_W-1:0] wr_ptr,
   output logic              dma_bank,
   output logic              blk_done
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BLK_LEN - 1);

   assign blk_done = accept && (wr_ptr == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         dma_bank <= 1'b0;
      end else if (accept) begin
         if (blk_done) begin
            wr_ptr   <= '0;
            dma_bank <= ~dma_bank;
         end else begin
            wr_ptr <= wr_ptr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pp_irq_ctrl.sv
module pp_irq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic blk_done,
   input  logic irq_ack,
   output logic irq,
   output logic overrun
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         overrun <= 1'b0;
      end else begin
         // completion wins over acknowledge
         if (blk_done)     irq <= 1'b1;
         else if (irq_ack) irq <= 1'b0;
         if (blk_done && irq && !irq_ack) overrun <= 1'b1;
      end
   end
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned BLK_LEN = 6,
   parameter int unsigned ADDR_W  = pp_pkg::ptr_width(BLK_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   output logic              s_ready,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_bank,
   output logic [ADDR_W-1:0] fill_level,
   output logic              irq,
   input  logic              irq_ack,
   output logic              overrun
);
   localparam int unsigned NB = pp_pkg::NUM_BANKS;

   if (BLK_LEN < 2) begin : g_bad_len
      $error("BLK_LEN must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if ((2 ** ADDR_W) < BLK_LEN) begin : g_bad_addr
      $error("ADDR_W too narrow for BLK_LEN");
   end

   logic              ready_q;
   logic              accept;
   logic              dma_bank;
   logic              blk_done;
   logic [ADDR_W-1:0] wr_ptr;
   logic [DATA_W-1:0] bank_rd [NB];

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end

   assign s_ready = ready_q;
   assign accept  = s_valid && ready_q;

   pp_fill_ctrl #(.BLK_LEN(BLK_LEN), .ADDR_W(ADDR_W)) u_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .wr_ptr   (wr_ptr),
      .dma_bank (dma_bank),
      .blk_done (blk_done)
   );

   pp_irq_ctrl u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .blk_done (blk_done),
      .irq_ack  (irq_ack),
      .irq      (irq),
      .overrun  (overrun)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      pp_bank #(.DATA_W(DATA_W), .DEPTH(BLK_LEN), .ADDR_W(ADDR_W)) u_bank (
         .clk     (clk),
         .wr_en   (accept && (dma_bank == 1'(b))),
         .wr_addr (wr_ptr),
         .wr_data (s_data),
         .rd_addr (cpu_addr),
         .rd_data (bank_rd[b])
      );
   end

   assign cpu_bank   = ~dma_bank;
   assign cpu_rdata  = bank_rd[cpu_bank];
   assign fill_level = wr_ptr;
endmodule

// File: rtl/pp_capture_chk.sv
module pp_capture_chk #(
   parameter int unsigned BLK_LEN = 6,
   parameter int unsigned ADDR_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_valid,
   input logic              s_ready,
   input logic              irq_ack,
   input logic [ADDR_W-1:0] fill_level,
   input logic              cpu_bank,
   input logic              irq,
   input logic              overrun
);
   logic last_acc;
   assign last_acc = s_valid && s_ready && (fill_level == ADDR_W'(BLK_LEN - 1));

   p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, fill_level} < (ADDR_W+1)'(BLK_LEN));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      last_acc |=> (fill_level == '0));

   p_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      last_acc |=> (cpu_bank != $past(cpu_bank)));

   p_hold_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !last_acc |=> $stable(cpu_bank));

   p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      last_acc |=> irq);

   p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !last_acc) |=> !irq);

   p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (last_acc && irq && !irq_ack) |=> overrun);

   p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !s_valid |=> $stable(fill_level));
endmodule

bind pingpong_capture pp_capture_chk #(.BLK_LEN(BLK_LEN), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .s_valid    (s_valid),
   .s_ready    (s_ready),
   .irq_ack    (irq_ack),
   .fill_level (fill_level),
   .cpu_bank   (cpu_bank),
   .irq        (irq),
   .overrun    (overrun)
);

// File: tb/pingpong_capture_tb.sv
module pingpong_capture_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int NBLK = 6;
   localparam int AW = 3;
   localparam int NVEC = 20;

   typedef struct packed {
      logic          v;
      logic          ack;
      logic [AW-1:0] fill;
      logic          cb;
      logic          irq;
      logic          ovr;
   } vec_t;

   // stimulus and the state expected after the edge
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0},
      '{1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0},
      '{1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0},
      '{1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0},
      '{1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0},
      '{1'b1, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0},
      '{1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 1'b0},
      '{1'b1, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0},
      '{1'b1, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
      '{1'b1, 1'b0, 3'd5, 1'b1, 1'b1, 1'b0},
      '{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_valid = 1'b0;
   logic [DW-1:0] s_data = '0;
   logic          s_ready;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_bank;
   logic [AW-1:0] fill_level;
   logic          irq;
   logic          irq_ack = 1'b0;
   logic          overrun;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pingpong_capture #(.DATA_W(DW), .BLK_LEN(NBLK), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
      .s_ready(s_ready), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
      .cpu_bank(cpu_bank), .fill_level(fill_level), .irq(irq),
      .irq_ack(irq_ack), .overrun(overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [DW-1:0] d, input logic ack);
      @(negedge clk);
      s_valid = v;
      s_data  = d;
      irq_ack = ack;
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input int a, input logic [DW-1:0] exp, input string req);
      cpu_addr = AW'(a);
      #1;
      chk(req, 32'(cpu_rdata), 32'(exp));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      s_valid = 1'b0;
      irq_ack = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk("R1 ready low in reset", 32'(s_ready), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
   endtask

   initial begin
      do_reset();
      chk("R1 ready", 32'(s_ready), 32'd1);
      chk("R1 cpu_bank", 32'(cpu_bank), 32'd1);
      chk("R1 fill", 32'(fill_level), 32'd0);
      chk("R1 irq", 32'(irq), 32'd0);
      chk("R1 overrun", 32'(overrun), 32'd0);

      // table walk: R2 R3 R5 R6 R7 R9
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i].v, DW'(16'h100 + i), VEC[i].ack);
         chk($sformatf("R2/R9 fill vec%0d", i), 32'(fill_level), 32'(VEC[i].fill));
         chk($sformatf("R3 cpu_bank vec%0d", i), 32'(cpu_bank), 32'(VEC[i].cb));
         chk($sformatf("R5/R6 irq vec%0d", i), 32'(irq), 32'(VEC[i].irq));
         chk($sformatf("R7 overrun vec%0d", i), 32'(overrun), 32'(VEC[i].ovr));
      end

      // R4: the processor owns bank 0, filled by vectors 14..19
      for (int a = 0; a < NBLK; a++) rd(a, DW'(16'h10E + a), "R4 readback");
      // R8: addresses past the block read zero
      rd(6, '0, "R8 addr 6");
      rd(7, '0, "R8 addr 7");

      // R10: a new fill goes to bank 1 and leaves bank 0 alone
      step(1'b1, 16'hBEEF, 1'b0);
      step(1'b1, 16'hCAFE, 1'b0);
      rd(0, 16'h10E, "R10 addr0 frozen");
      rd(1, 16'h10F, "R10 addr1 frozen");
      chk("R7 overrun sticky", 32'(overrun), 32'd1);

      // R6: acknowledge on the completing edge keeps irq, no overrun
      do_reset();
      for (int k = 0; k < NBLK; k++) step(1'b1, DW'(16'h200 + k), 1'b0);
      chk("R5 irq after first block", 32'(irq), 32'd1);
      for (int k = 0; k < NBLK - 1; k++) step(1'b1, DW'(16'h300 + k), 1'b0);
      step(1'b1, 16'h3FF, 1'b1);
      chk("R6 irq kept on completion+ack", 32'(irq), 32'd1);
      chk("R6 no overrun", 32'(overrun), 32'd0);
      chk("R3 bank after two blocks", 32'(cpu_bank), 32'd1);
      step(1'b0, '0, 1'b1);
      chk("R6 ack clears", 32'(irq), 32'd0);
      // R4: bank 1 now holds the second block in order
      for (int a = 0; a < NBLK - 1; a++) rd(a, DW'(16'h300 + a), "R4 second block");
      rd(NBLK - 1, 16'h3FF, "R4 second block last");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule